// File: doc/BRIEF.md
# Regulator Startup and Protection Supervisor

This block sequences power-up and handles protection for a controller that drives two switching outputs and two linear outputs. Analog comparators outside the block turn voltages and currents into logic flags. The supervisor takes those flags along with:

- three supply-ready indications;
- a soft-start hold input;
- a 5-bit core voltage code;
- a level that selects the output voltage of the second switching output.

It drives these outputs:

- charge and discharge commands for the soft-start ramp;
- a common inhibit for all outputs;
- a latched fault flag;
- a command that forces the low-side switch on;
- a power-good flag.

Every raw flag first passes through a two-flop synchroniser. The soft-start level is held as an internal counter. It counts up toward a full value while charging and down toward zero while discharging.

A start needs all three supplies, the hold released, a usable voltage code and a fully discharged ramp. The ramp then charges and the outputs come out of inhibit. Protection works in three ways:

- An over-current event, or an under-voltage on a linear output once running, counts as a strike. Each strike restarts the ramp from zero, and the third strike latches the fault.
- Over-voltage on the core output latches the fault at once.
- A change of the select level while operating also latches the fault.

Once latched, the fault is cleared only by cycling the bias supply.

Top module: `regsup_top`

## Requirements
- R1: No ramp charge happens and outputs stay inhibited until the bias, main and auxiliary supply-ready inputs are all high. Once they are, with the hold released and the ramp at zero, charging starts.
- R2: An over-voltage flag latches `fault` immediately, with no retry. The fault stays set after the flag goes away.
- R3: `lowside_force` is high exactly while the synchronised over-voltage flag is high.
- R4: A pulse on any over-current flag while ramping or running does four things: it inhibits all outputs, discharges the ramp to zero, adds one strike, and then starts a fresh ramp.
- R5: On the third strike `fault` latches. Outputs then stay inhibited and the ramp is not recharged.
- R6: Under-voltage on either linear output is ignored while the ramp is charging. Once running with the ramp full, it counts as an over-current strike.
- R7: Strikes and `fault` are cleared only by the bias supply-ready going low. Dropping the auxiliary supply leaves `fault` set.
- R8: Voltage code 5'b11111 inhibits all outputs and forces `pgood` low. Any other code permits operation.
- R9: `pgood` is high only while running, with the core-window flag high, both linear under-voltage flags low, the code not 5'b11111 and no fault.
- R10: A change of `sel_lvl` after a start latches `fault`. The level present at the start of the next ramp is accepted.
- R11: `ss_hold_n` low shuts every output down (inhibit high, `pgood` low) and discharges the ramp.
- R12: Raw flags reach the logic through two flops. A change in the core-window flag or the over-voltage flag affects `pgood` or `lowside_force` two rising edges later, not one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_bias_ok | input | 1 | Bias supply above its threshold |
| por_main_ok | input | 1 | Main supply above its threshold |
| por_aux_ok | input | 1 | Auxiliary supply above its threshold |
| ss_hold_n | input | 1 | Low holds the soft-start ramp down and shuts down |
| oc_raw | input | NUM_SW | Over-current flag per switching output |
| ov_raw | input | 1 | Over-voltage flag on the core output |
| uv_raw | input | NUM_LIN | Under-voltage flag per linear output |
| core_win_raw | input | 1 | Core output inside its regulation window |
| vcode | input | CODE_W | Core voltage code; all ones inhibits |
| sel_lvl | input | 1 | Output level select of the second switching output |
| ss_charge | output | 1 | Charge the soft-start ramp |
| ss_discharge | output | 1 | Discharge the soft-start ramp |
| out_inhibit | output | 1 | Disable all regulator outputs |
| fault | output | 1 | Latched fault |
| lowside_force | output | 1 | Force the core low-side switch on |
| pgood | output | 1 | Power good |

## Verification
A raw flag takes two rising edges to clear the synchroniser, so `lowside_force` and `pgood` (through the window and under-voltage flags) respond on the second edge after a change. Outputs that come from the state machine (`out_inhibit`, `fault`, ramp commands) respond on the third edge. The bench changes inputs on falling edges and samples on falling edges. It checks one edge and two edges after a change to pin down the two-edge latency, and four edges after a change for state-driven results. Any restart needs a full discharge plus a full charge of SS_MAX steps each, so the bench waits 2*SS_MAX+12 cycles before expecting a running state again.

// File: rtl/regsup_pkg.sv
package regsup_pkg;
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_RAMP  = 3'd1,
        ST_RUN   = 3'd2,
        ST_DISCH = 3'd3,
        ST_FAULT = 3'd4
    } sup_state_e;
endpackage

// File: rtl/regsup_sync.sv
module regsup_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/regsup_ssramp.sv
module regsup_ssramp #(
    parameter int SS_MAX = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic charge_en,
    output logic full,
    output logic zero
);
    localparam int LVL_W = $clog2(SS_MAX + 1);

    logic [LVL_W-1:0] lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_q;
        if (charge_en) begin
            if (lvl_q != LVL_W'(SS_MAX)) lvl_d = lvl_q + 1'b1;
        end else if (lvl_q != '0) begin
            lvl_d = lvl_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    assign full = (lvl_q == LVL_W'(SS_MAX));
    assign zero = (lvl_q == '0);
endmodule

// File: rtl/regsup_ctrl.sv
module regsup_ctrl
    import regsup_pkg::*;
#(
    parameter int MAX_STRIKES = 3,
    parameter int CNT_W       = $clog2(MAX_STRIKES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bias_ok,
    input  logic             supplies_ok,
    input  logic             hold_n,
    input  logic             oc_any,
    input  logic             ov,
    input  logic             uv_any,
    input  logic             code_inh,
    input  logic             sel,
    input  logic             ss_full,
    input  logic             ss_zero,
    output sup_state_e       state_o,
    output logic             fault_o,
    output logic [CNT_W-1:0] strikes_o
);
    typedef struct packed {
        sup_state_e       state;
        logic             fault;
        logic [CNT_W-1:0] strikes;
        logic             sel_ref;
    } ctrl_t;

    ctrl_t r_q, r_d;
    logic  active;
    logic  oc_evt;

    assign active = (r_q.state == ST_RAMP) || (r_q.state == ST_RUN) ||
                    (r_q.state == ST_DISCH);

    always_comb begin
        r_d    = r_q;
        oc_evt = 1'b0;
        if (!bias_ok) begin
            r_d.state   = ST_OFF;
            r_d.fault   = 1'b0;
            r_d.strikes = '0;
        end else if (r_q.fault || ov || (active && (sel != r_q.sel_ref))) begin
            r_d.state = ST_FAULT;
            r_d.fault = 1'b1;
        end else if (!supplies_ok || !hold_n || code_inh) begin
            r_d.state = ST_OFF;
        end else begin
            case (r_q.state)
                ST_OFF: begin
                    if (ss_zero) begin
                        r_d.state   = ST_RAMP;
                        r_d.sel_ref = sel;
                    end
                end
                ST_RAMP: begin
                    if (oc_any)       oc_evt    = 1'b1;
                    else if (ss_full) r_d.state = ST_RUN;
                end
                ST_RUN: begin
                    if (oc_any || (uv_any && ss_full)) oc_evt = 1'b1;
                end
                ST_DISCH: begin
                    if (ss_zero) r_d.state = ST_RAMP;
                end
                default: r_d.state = r_q.state;
            endcase
            if (oc_evt) begin
                r_d.strikes = r_q.strikes + 1'b1;
                if (r_d.strikes == CNT_W'(MAX_STRIKES)) begin
                    r_d.state = ST_FAULT;
                    r_d.fault = 1'b1;
                end else begin
                    r_d.state = ST_DISCH;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_OFF, fault: 1'b0, strikes: '0, sel_ref: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o   = r_q.state;
    assign fault_o   = r_q.fault;
    assign strikes_o = r_q.strikes;
endmodule

// File: rtl/regsup_top.sv
module regsup_top
    import regsup_pkg::*;
#(
    parameter int NUM_SW      = 2,
    parameter int NUM_LIN     = 2,
    parameter int CODE_W      = 5,
    parameter int SS_MAX      = 16,
    parameter int MAX_STRIKES = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por_bias_ok,
    input  logic               por_main_ok,
    input  logic               por_aux_ok,
    input  logic               ss_hold_n,
    input  logic [NUM_SW-1:0]  oc_raw,
    input  logic               ov_raw,
    input  logic [NUM_LIN-1:0] uv_raw,
    input  logic               core_win_raw,
    input  logic [CODE_W-1:0]  vcode,
    input  logic               sel_lvl,
    output logic               ss_charge,
    output logic               ss_discharge,
    output logic               out_inhibit,
    output logic               fault,
    output logic               lowside_force,
    output logic               pgood
);
    localparam int SYNC_W = 7 + NUM_SW + NUM_LIN + CODE_W;
    localparam int CNT_W  = $clog2(MAX_STRIKES + 1);

    logic               bias_s, main_s, aux_s, hold_s, ov_s, win_s, sel_s;
    logic [NUM_SW-1:0]  oc_s;
    logic [NUM_LIN-1:0] uv_s;
    logic [CODE_W-1:0]  code_s;
    logic               code_inh, ss_full, ss_zero, running, charge_en;
    sup_state_e         state;
    logic [CNT_W-1:0]   strikes;

    regsup_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({por_bias_ok, por_main_ok, por_aux_ok, ss_hold_n, ov_raw,
                core_win_raw, sel_lvl, oc_raw, uv_raw, vcode}),
        .dout ({bias_s, main_s, aux_s, hold_s, ov_s,
                win_s, sel_s, oc_s, uv_s, code_s})
    );

    assign code_inh = (code_s == '1);

    regsup_ctrl #(.MAX_STRIKES(MAX_STRIKES), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bias_ok    (bias_s),
        .supplies_ok(bias_s & main_s & aux_s),
        .hold_n     (hold_s),
        .oc_any     (|oc_s),
        .ov         (ov_s),
        .uv_any     (|uv_s),
        .code_inh   (code_inh),
        .sel        (sel_s),
        .ss_full    (ss_full),
        .ss_zero    (ss_zero),
        .state_o    (state),
        .fault_o    (fault),
        .strikes_o  (strikes)
    );

    assign running   = (state == ST_RUN);
    assign charge_en = (state == ST_RAMP) || running;

    regsup_ssramp #(.SS_MAX(SS_MAX)) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .charge_en(charge_en),
        .full     (ss_full),
        .zero     (ss_zero)
    );

    assign ss_charge     = charge_en & ~ss_full;
    assign ss_discharge  = ~charge_en & ~ss_zero;
    assign out_inhibit   = ~charge_en;
    assign lowside_force = ov_s;
    assign pgood         = running & win_s & ~(|uv_s) & ~code_inh & ~fault;
endmodule

// File: rtl/regsup_chk.sv
module regsup_chk #(
    parameter int MAX_STRIKES = 3,
    parameter int CNT_W       = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fault,
    input logic             out_inhibit,
    input logic             pgood,
    input logic             ss_charge,
    input logic             ss_discharge,
    input logic             bias_s,
    input logic             ss_zero,
    input logic             code_inh,
    input logic [CNT_W-1:0] strikes
);
    AST_FAULT_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> out_inhibit); // R5
    AST_FAULT_CLEAR_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault) |-> !$past(bias_s)); // R7
    AST_STRIKE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        strikes <= CNT_W'(MAX_STRIKES)); // R5
    AST_RAMP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ss_charge && ss_discharge)); // R4
    AST_START_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_inhibit) |-> $past(ss_zero)); // R4
    AST_CODE_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
        code_inh |=> out_inhibit); // R8
    AST_PGOOD_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        pgood |-> !out_inhibit); // R9
    AST_NO_BIAS_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
        !bias_s |=> out_inhibit); // R1
endmodule

bind regsup_top regsup_chk #(.MAX_STRIKES(MAX_STRIKES), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault       (fault),
    .out_inhibit (out_inhibit),
    .pgood       (pgood),
    .ss_charge   (ss_charge),
    .ss_discharge(ss_discharge),
    .bias_s      (bias_s),
    .ss_zero     (ss_zero),
    .code_inh    (code_inh),
    .strikes     (strikes)
);

// File: tb/regsup_top_bench.sv
module regsup_top_bench;
    localparam int SS_MAX  = 16;
    localparam int RESTART = 2 * SS_MAX + 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_bias_ok = 1'b0, por_main_ok = 1'b0, por_aux_ok = 1'b0;
    logic       ss_hold_n = 1'b0, ov_raw = 1'b0, core_win_raw = 1'b0, sel_lvl = 1'b0;
    logic [1:0] oc_raw = '0, uv_raw = '0;
    logic [4:0] vcode = 5'd10;
    logic       ss_charge, ss_discharge, out_inhibit, fault, lowside_force, pgood;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    regsup_top #(.SS_MAX(SS_MAX)) u_regsup_top (
        .clk(clk), .rst_n(rst_n),
        .por_bias_ok(por_bias_ok), .por_main_ok(por_main_ok), .por_aux_ok(por_aux_ok),
        .ss_hold_n(ss_hold_n), .oc_raw(oc_raw), .ov_raw(ov_raw), .uv_raw(uv_raw),
        .core_win_raw(core_win_raw), .vcode(vcode), .sel_lvl(sel_lvl),
        .ss_charge(ss_charge), .ss_discharge(ss_discharge), .out_inhibit(out_inhibit),
        .fault(fault), .lowside_force(lowside_force), .pgood(pgood)
    );

    function automatic logic exp_inhibit(input logic [4:0] code);
        return (code == 5'b11111);
    endfunction

    function automatic logic exp_pgood(input logic [4:0] code, input logic win,
                                       input logic [1:0] uv);
        return !exp_inhibit(code) && win && (uv == 2'b00);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bias_cycle();
        por_bias_ok = 1'b0;
        tick(6);
        chk("R7 bias drop clears fault", fault, 1'b0);
        por_bias_ok = 1'b1;
        tick(RESTART);
    endtask

    task automatic oc_pulse(input int ch);
        oc_raw[ch] = 1'b1;
        tick(2);
        oc_raw = '0;
        tick(2);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 reset inhibit", out_inhibit, 1'b1);
        chk("R1 reset no charge", ss_charge, 1'b0);
        chk("R2 reset fault", fault, 1'b0);
        chk("R9 reset pgood", pgood, 1'b0);

        // R1: two of three supplies is not enough
        ss_hold_n = 1'b1; core_win_raw = 1'b1;
        por_bias_ok = 1'b1; por_main_ok = 1'b1;
        tick(40);
        chk("R1 aux missing no charge", ss_charge, 1'b0);
        chk("R1 aux missing inhibit", out_inhibit, 1'b1);
        por_aux_ok = 1'b1;
        tick(4);
        chk("R1 charge starts", ss_charge, 1'b1);
        tick(SS_MAX + 4);
        chk("R1 running", out_inhibit, 1'b0);
        chk("R9 pgood running", pgood, 1'b1);

        // R12 / R9: window flag latency
        core_win_raw = 1'b0;
        tick(1);
        chk("R12 pgood after one edge", pgood, 1'b1);
        tick(1);
        chk("R12 pgood after two edges", pgood, 1'b0);
        core_win_raw = 1'b1;
        tick(3);
        chk("R9 pgood back", pgood, 1'b1);

        // R6: under-voltage while running counts as strike 1
        uv_raw = 2'b10;
        tick(4);
        chk("R6 uv running discharges", ss_discharge, 1'b1);
        chk("R6 uv running inhibits", out_inhibit, 1'b1);
        uv_raw = 2'b00;
        tick(RESTART);
        chk("R4 restart after uv strike", out_inhibit, 1'b0);

        // R11: hold shuts down
        ss_hold_n = 1'b0;
        tick(4);
        chk("R11 hold inhibits", out_inhibit, 1'b1);
        chk("R11 hold pgood low", pgood, 1'b0);
        chk("R11 hold discharges", ss_discharge, 1'b1);
        tick(SS_MAX + 6);
        chk("R11 hold ramp empty", ss_discharge, 1'b0);
        ss_hold_n = 1'b1;
        tick(4);
        chk("R11 release charges", ss_charge, 1'b1);
        // R6: under-voltage ignored during ramp
        uv_raw = 2'b01;
        tick(4);
        chk("R6 uv ignored in ramp charge", ss_charge, 1'b1);
        chk("R6 uv ignored in ramp discharge", ss_discharge, 1'b0);
        chk("R6 uv ignored in ramp fault", fault, 1'b0);
        uv_raw = 2'b00;
        tick(SS_MAX + 6);
        chk("R6 ramp completes", pgood, 1'b1);

        // R8 / R9: random code and window
        for (int i = 0; i < 16; i++) begin
            logic [4:0] c;
            logic       w;
            c = ($urandom % 4 == 0) ? 5'b11111 : 5'($urandom % 31);
            w = 1'($urandom % 2);
            vcode = c; core_win_raw = w;
            tick(RESTART);
            chk("R8 code inhibit", out_inhibit, exp_inhibit(c));
            chk("R9 pgood random", pgood, exp_pgood(c, w, uv_raw));
        end
        vcode = 5'b11111; core_win_raw = 1'b1;
        tick(6);
        chk("R8 code all ones pgood", pgood, 1'b0);
        vcode = 5'd3;
        tick(RESTART);
        chk("R8 code released", out_inhibit, 1'b0);

        // R4 / R5: three strikes
        bias_cycle();
        oc_pulse(0);
        chk("R4 oc discharges", ss_discharge, 1'b1);
        chk("R4 oc inhibits", out_inhibit, 1'b1);
        chk("R4 oc no fault", fault, 1'b0);
        tick(RESTART);
        chk("R4 oc restart", out_inhibit, 1'b0);
        oc_pulse(1);
        chk("R4 second strike no fault", fault, 1'b0);
        tick(RESTART);
        oc_pulse(0);
        chk("R5 third strike fault", fault, 1'b1);
        tick(40);
        chk("R5 fault holds", fault, 1'b1);
        chk("R5 fault inhibits", out_inhibit, 1'b1);
        chk("R5 no recharge", ss_charge, 1'b0);

        // R7: aux cycle does not clear, bias cycle does
        por_aux_ok = 1'b0;
        tick(6);
        por_aux_ok = 1'b1;
        tick(RESTART);
        chk("R7 aux cycle keeps fault", fault, 1'b1);
        por_bias_ok = 1'b0;
        tick(4);
        chk("R7 bias drop clears", fault, 1'b0);
        por_bias_ok = 1'b1;
        tick(RESTART);
        chk("R7 restart after clear", out_inhibit, 1'b0);

        // R2 / R3 / R12: over-voltage
        ov_raw = 1'b1;
        tick(1);
        chk("R12 lowside after one edge", lowside_force, 1'b0);
        tick(1);
        chk("R3 lowside forced", lowside_force, 1'b1);
        tick(2);
        chk("R2 ov fault", fault, 1'b1);
        chk("R2 ov inhibit", out_inhibit, 1'b1);
        ov_raw = 1'b0;
        tick(4);
        chk("R3 lowside released", lowside_force, 1'b0);
        tick(RESTART);
        chk("R2 no retry", fault, 1'b1);
        bias_cycle();

        // R10: select change while operating
        chk("R10 running before change", out_inhibit, 1'b0);
        sel_lvl = 1'b1;
        tick(4);
        chk("R10 select change fault", fault, 1'b1);
        bias_cycle();
        chk("R10 new level accepted", out_inhibit, 1'b0);
        chk("R10 new level no fault", fault, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule